// File: doc/BRIEF.md
# Endpoint Control Bank with Token Verdict

This block keeps one small control register per endpoint and uses it to judge each token the serial interface engine (SIE) receives. Firmware reaches the registers through a simple CPU port. The SIE can set or clear any endpoint's stall flag through its own strobes. When a token arrives, the block looks up the addressed endpoint's register. It answers with one of three verdicts: no handshake, accept, or stall.

Each register has four live bits. Bit 3 is the control-disable flag, bit 2 enables OUT, bit 1 enables IN and bit 0 is the stall flag. Bits 7..4 do not exist. After a bus reset, firmware normally writes 06h to endpoint 0, which makes it a control endpoint that takes SETUP, IN and OUT.

A two-state machine times the answer. ST_IDLE moves to ST_ANSWER on a token pulse (transition TOKEN_SEEN). ST_ANSWER goes back to ST_IDLE when no new token arrives (transition ANSWER_DONE), or stays in ST_ANSWER when one does (transition BACK_TO_BACK). The verdict is presented while the machine is in ST_ANSWER.

Top module: `ep_token_resp`

## Requirements
- R1: After reset, every endpoint register reads 00h, `rsp_vld` is 0 and `rsp_code` is NONE (0).
- R2: Read data bits 7..4 are always 0, and writing ones to them has no effect. Bit 3 is control-disable, bit 2 OUT enable, bit 1 IN enable and bit 0 stall.
- R3: When OUT enable and IN enable are both 0, every token gets NONE, whatever the control-disable and stall bits hold.
- R4: For bits 3..1, code 101 accepts IN only, 110 accepts OUT only and 111 accepts IN and OUT but not SETUP. A token that is not accepted gets NONE.
- R5: Code 011 accepts IN, OUT and SETUP. Codes 001 and 010 accept only their single direction and never SETUP.
- R6: When the stall bit is 1 and at least one direction is enabled, any IN, OUT or SETUP token gets STALL (2), overriding the direction bits.
- R7: The SIE set strobe forces the addressed endpoint's stall bit to 1 and the clear strobe forces it to 0, and set wins over clear. In a cycle where the SIE and a CPU write hit the same register, the stall bit follows the SIE and bits 3..1 follow the CPU.
- R8: A token addressed to an endpoint number at or above N_EP gets NONE. CPU writes to such addresses are ignored, and reads from them return 00h.
- R9: The verdict shows on `rsp_code` with `rsp_vld` = 1 in the cycle after the token pulse, and `rsp_vld` lasts one cycle per token. Token kind encodings are OUT = 0, IN = 1 and SETUP = 2. Kind 3 always gets NONE. Verdict codes are NONE = 0, ACCEPT = 1 and STALL = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_addr | input | ADDR_W | CPU register select (endpoint number) |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Register contents at `cpu_addr` |
| sie_stall_set | input | 1 | SIE request to set the stall bit |
| sie_stall_clr | input | 1 | SIE request to clear the stall bit |
| sie_ep | input | ADDR_W | Endpoint targeted by the SIE strobes |
| tok_vld | input | 1 | One-cycle token pulse |
| tok_kind | input | 2 | Token kind: OUT = 0, IN = 1, SETUP = 2 |
| tok_ep | input | ADDR_W | Endpoint number of the token |
| rsp_vld | output | 1 | Verdict valid (state ST_ANSWER) |
| rsp_code | output | 2 | Verdict: NONE = 0, ACCEPT = 1, STALL = 2 |

## Verification
The embedded assertions run on every cycle and cover several behaviours:
- the SIE strobes' effect on each stall bit, including set beating clear;
- that untouched registers hold their value;
- that the read data's upper nibble is zero;
- that a verdict only follows a token;
- that out-of-range tokens get NONE.

The decoding of the enable codes into verdicts is shown only by the bench's directed scenarios, since each one needs a configured register followed by a token. Those scenarios cover the stall override, the SIE-over-CPU conflict on one register, and exact response timing.

// File: rtl/ep_ctl_pkg.sv
package ep_ctl_pkg;
    typedef enum logic [1:0] {
        TK_OUT   = 2'd0,
        TK_IN    = 2'd1,
        TK_SETUP = 2'd2,
        TK_RSVD  = 2'd3
    } tok_kind_e;

    typedef enum logic [1:0] {
        RS_NONE   = 2'd0,
        RS_ACCEPT = 2'd1,
        RS_STALL  = 2'd2
    } rsp_e;

    localparam int CTL_W     = 4;
    localparam int BIT_STALL = 0;
    localparam int BIT_IN    = 1;
    localparam int BIT_OUT   = 2;
    localparam int BIT_CDIS  = 3;

    typedef logic [CTL_W-1:0] ep_ctl_t;
endpackage

// File: rtl/ep_reg_bank.sv
module ep_reg_bank
    import ep_ctl_pkg::*;
#(
    parameter int N_EP   = 3,
    parameter int ADDR_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_we,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [CTL_W-1:0]      cpu_wdata,
    input  logic                  sie_stall_set,
    input  logic                  sie_stall_clr,
    input  logic [ADDR_W-1:0]     sie_ep,
    output logic [N_EP*CTL_W-1:0] ctl_flat
);
    for (genvar i = 0; i < N_EP; i++) begin : g_ep
        logic    cpu_hit;
        logic    sie_hit;
        ep_ctl_t q;
        ep_ctl_t d;

        assign cpu_hit = cpu_we && (cpu_addr == ADDR_W'(i));
        assign sie_hit = (sie_stall_set || sie_stall_clr) && (sie_ep == ADDR_W'(i));

        always_comb begin
            d = cpu_hit ? cpu_wdata : q;
            if (sie_hit) begin
                d[BIT_STALL] = sie_stall_set;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else begin
                q <= d;
            end
        end

        assign ctl_flat[i*CTL_W +: CTL_W] = q;

        AST_SIE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (sie_stall_set && sie_ep == ADDR_W'(i)) |=> ctl_flat[i*CTL_W + BIT_STALL]); // R7
        AST_SIE_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (sie_stall_clr && !sie_stall_set && sie_ep == ADDR_W'(i))
            |=> !ctl_flat[i*CTL_W + BIT_STALL]); // R7
        AST_UNTOUCHED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!(cpu_we && cpu_addr == ADDR_W'(i)) &&
             !((sie_stall_set || sie_stall_clr) && sie_ep == ADDR_W'(i)))
            |=> $stable(ctl_flat[i*CTL_W +: CTL_W])); // R8
    end
endmodule

// File: rtl/ep_tok_decide.sv
module ep_tok_decide
    import ep_ctl_pkg::*;
#(
    parameter int N_EP   = 3,
    parameter int ADDR_W = 4
) (
    input  logic [N_EP*CTL_W-1:0] ctl_flat,
    input  logic [1:0]            tok_kind,
    input  logic [ADDR_W-1:0]     tok_ep,
    output logic [1:0]            verdict
);
    ep_ctl_t sel;
    logic    hit;
    logic    en_in;
    logic    en_out;
    logic    setup_ok;

    always_comb begin
        sel = '0;
        hit = 1'b0;
        for (int i = 0; i < N_EP; i++) begin
            if (tok_ep == ADDR_W'(i)) begin
                sel = ctl_flat[i*CTL_W +: CTL_W];
                hit = 1'b1;
            end
        end
    end

    assign en_in    = sel[BIT_IN];
    assign en_out   = sel[BIT_OUT];
    assign setup_ok = en_in && en_out && !sel[BIT_CDIS];

    always_comb begin
        verdict = RS_NONE;
        if (hit && (en_in || en_out) && tok_kind != TK_RSVD) begin
            if (sel[BIT_STALL]) begin
                verdict = RS_STALL;
            end else begin
                unique case (tok_kind)
                    TK_IN:    verdict = en_in    ? RS_ACCEPT : RS_NONE;
                    TK_OUT:   verdict = en_out   ? RS_ACCEPT : RS_NONE;
                    TK_SETUP: verdict = setup_ok ? RS_ACCEPT : RS_NONE;
                    default:  verdict = RS_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ep_token_resp.sv
module ep_token_resp
    import ep_ctl_pkg::*;
#(
    parameter int N_EP   = 3,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic              sie_stall_set,
    input  logic              sie_stall_clr,
    input  logic [ADDR_W-1:0] sie_ep,
    input  logic              tok_vld,
    input  logic [1:0]        tok_kind,
    input  logic [ADDR_W-1:0] tok_ep,
    output logic              rsp_vld,
    output logic [1:0]        rsp_code
);
    localparam logic [ADDR_W:0] EP_LIMIT = (ADDR_W+1)'(N_EP);

    typedef enum logic {ST_IDLE, ST_ANSWER} state_e;

    state_e                state_q;
    state_e                state_d;
    logic [N_EP*CTL_W-1:0] ctl_flat;
    logic [1:0]            verdict;
    logic [1:0]            code_q;
    ep_ctl_t               rd_sel;

    ep_reg_bank #(.N_EP(N_EP), .ADDR_W(ADDR_W)) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_we        (cpu_we),
        .cpu_addr      (cpu_addr),
        .cpu_wdata     (cpu_wdata[CTL_W-1:0]),
        .sie_stall_set (sie_stall_set),
        .sie_stall_clr (sie_stall_clr),
        .sie_ep        (sie_ep),
        .ctl_flat      (ctl_flat)
    );

    ep_tok_decide #(.N_EP(N_EP), .ADDR_W(ADDR_W)) u_decide (
        .ctl_flat (ctl_flat),
        .tok_kind (tok_kind),
        .tok_ep   (tok_ep),
        .verdict  (verdict)
    );

    always_comb begin
        rd_sel = '0;
        for (int i = 0; i < N_EP; i++) begin
            if (cpu_addr == ADDR_W'(i)) begin
                rd_sel = ctl_flat[i*CTL_W +: CTL_W];
            end
        end
    end
    assign cpu_rdata = {4'b0000, rd_sel};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tok_vld) state_d = ST_ANSWER;
            ST_ANSWER: state_d = tok_vld ? ST_ANSWER : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= RS_NONE;
        end else begin
            code_q <= tok_vld ? verdict : RS_NONE;
        end
    end

    assign rsp_vld  = (state_q == ST_ANSWER);
    assign rsp_code = code_q;

    always_comb begin
        AST_RD_UPPER_ZERO: assert (cpu_rdata[7:4] == 4'b0000); // R2
    end

    AST_RSP_FOLLOWS_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> $past(tok_vld)); // R9
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_code != 2'd3); // R9
    AST_OUT_OF_RANGE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_vld && {1'b0, tok_ep} >= EP_LIMIT) |=> (rsp_vld && rsp_code == RS_NONE)); // R8
endmodule

// File: tb/test_ep_token_resp.sv
`timescale 1ns/1ps
module test_ep_token_resp;
    localparam int N_EP   = 3;
    localparam int ADDR_W = 4;
    localparam logic [1:0] K_OUT = 2'd0, K_IN = 2'd1, K_SETUP = 2'd2, K_RSVD = 2'd3;
    localparam logic [1:0] V_NONE = 2'd0, V_ACC = 2'd1, V_STALL = 2'd2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [7:0]        cpu_wdata = '0;
    logic [7:0]        cpu_rdata;
    logic              sie_stall_set = 1'b0;
    logic              sie_stall_clr = 1'b0;
    logic [ADDR_W-1:0] sie_ep = '0;
    logic              tok_vld = 1'b0;
    logic [1:0]        tok_kind = '0;
    logic [ADDR_W-1:0] tok_ep = '0;
    logic              rsp_vld;
    logic [1:0]        rsp_code;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    ep_token_resp #(.N_EP(N_EP), .ADDR_W(ADDR_W)) i_ep_token_resp (
        .clk(clk), .rst_n(rst_n),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .sie_stall_set(sie_stall_set), .sie_stall_clr(sie_stall_clr), .sie_ep(sie_ep),
        .tok_vld(tok_vld), .tok_kind(tok_kind), .tok_ep(tok_ep),
        .rsp_vld(rsp_vld), .rsp_code(rsp_code)
    );

    task automatic check(string req, int actual, int expected);
        n_tests++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
        end
    endtask

    task automatic wr(int ep, logic [7:0] data);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = ADDR_W'(ep); cpu_wdata = data;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic rd_check(string req, int ep, logic [7:0] expected);
        @(negedge clk);
        cpu_addr = ADDR_W'(ep);
        #1;
        check(req, cpu_rdata, expected);
    endtask

    task automatic tok_check(string req, int ep, logic [1:0] kind, logic [1:0] expected);
        @(negedge clk);
        tok_vld = 1'b1; tok_kind = kind; tok_ep = ADDR_W'(ep);
        @(negedge clk);
        tok_vld = 1'b0;
        check({req, " vld"}, rsp_vld, 1);
        check(req, rsp_code, expected);
    endtask

    task automatic t_reset();
        check("R1 vld", rsp_vld, 0);
        check("R1 code", rsp_code, V_NONE);
        for (int e = 0; e < N_EP; e++) rd_check("R1 reg", e, 8'h00);
    endtask

    task automatic t_unimpl();
        wr(0, 8'hF6);
        rd_check("R2 upper nibble", 0, 8'h06);
        wr(1, 8'hAB);
        rd_check("R2 bits", 1, 8'h0B);
    endtask

    task automatic t_disabled();
        wr(2, 8'h09);
        tok_check("R3 in", 2, K_IN, V_NONE);
        tok_check("R3 out", 2, K_OUT, V_NONE);
        tok_check("R3 setup", 2, K_SETUP, V_NONE);
    endtask

    task automatic t_codes();
        wr(1, 8'h0A);
        tok_check("R4 101 in", 1, K_IN, V_ACC);
        tok_check("R4 101 out", 1, K_OUT, V_NONE);
        wr(1, 8'h0C);
        tok_check("R4 110 out", 1, K_OUT, V_ACC);
        tok_check("R4 110 in", 1, K_IN, V_NONE);
        wr(1, 8'h0E);
        tok_check("R4 111 in", 1, K_IN, V_ACC);
        tok_check("R4 111 out", 1, K_OUT, V_ACC);
        tok_check("R4 111 setup", 1, K_SETUP, V_NONE);
    endtask

    task automatic t_control();
        wr(0, 8'h06);
        tok_check("R5 011 setup", 0, K_SETUP, V_ACC);
        tok_check("R5 011 in", 0, K_IN, V_ACC);
        tok_check("R5 011 out", 0, K_OUT, V_ACC);
        wr(2, 8'h02);
        tok_check("R5 001 in", 2, K_IN, V_ACC);
        tok_check("R5 001 setup", 2, K_SETUP, V_NONE);
        wr(2, 8'h04);
        tok_check("R5 010 out", 2, K_OUT, V_ACC);
        tok_check("R5 010 in", 2, K_IN, V_NONE);
    endtask

    task automatic t_stall();
        wr(1, 8'h0B);
        tok_check("R6 stall in", 1, K_IN, V_STALL);
        tok_check("R6 stall out", 1, K_OUT, V_STALL);
        tok_check("R6 stall setup", 1, K_SETUP, V_STALL);
        wr(1, 8'h01);
        tok_check("R3 stall no dir", 1, K_IN, V_NONE);
    endtask

    task automatic t_sie();
        wr(2, 8'h06);
        @(negedge clk);
        sie_ep = ADDR_W'(2); sie_stall_set = 1'b1;
        @(negedge clk);
        sie_stall_set = 1'b0;
        rd_check("R7 sie set", 2, 8'h07);
        tok_check("R7 sie stall verdict", 2, K_OUT, V_STALL);
        @(negedge clk);
        sie_stall_clr = 1'b1;
        @(negedge clk);
        sie_stall_clr = 1'b0;
        rd_check("R7 sie clr", 2, 8'h06);
        @(negedge clk);
        sie_stall_set = 1'b1; sie_stall_clr = 1'b1;
        @(negedge clk);
        sie_stall_set = 1'b0; sie_stall_clr = 1'b0;
        rd_check("R7 set beats clr", 2, 8'h07);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = ADDR_W'(2); cpu_wdata = 8'h0A; sie_stall_clr = 1'b0; sie_stall_set = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0; sie_stall_set = 1'b0;
        rd_check("R7 sie over cpu set", 2, 8'h0B);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = ADDR_W'(2); cpu_wdata = 8'h07; sie_stall_clr = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0; sie_stall_clr = 1'b0;
        rd_check("R7 sie over cpu clr", 2, 8'h06);
    endtask

    task automatic t_range();
        wr(N_EP, 8'h06);
        rd_check("R8 read beyond", N_EP, 8'h00);
        for (int e = 0; e < N_EP; e++) begin
            wr(e, 8'h06);
        end
        wr(5, 8'h07);
        rd_check("R8 no alias", 0, 8'h06);
        tok_check("R8 tok beyond", N_EP, K_SETUP, V_NONE);
        tok_check("R8 tok far", 15, K_IN, V_NONE);
    endtask

    task automatic t_timing();
        wr(0, 8'h06);
        @(negedge clk);
        tok_vld = 1'b1; tok_kind = K_IN; tok_ep = '0;
        #1;
        check("R9 not same cycle", rsp_vld, 0);
        @(negedge clk);
        tok_kind = K_RSVD;
        check("R9 first vld", rsp_vld, 1);
        check("R9 first code", rsp_code, V_ACC);
        @(negedge clk);
        tok_vld = 1'b0;
        check("R9 b2b vld", rsp_vld, 1);
        check("R9 rsvd kind", rsp_code, V_NONE);
        @(negedge clk);
        check("R9 one shot", rsp_vld, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unimpl();
        t_disabled();
        t_codes();
        t_control();
        t_stall();
        t_sie();
        t_range();
        t_timing();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule